// File: doc/BRIEF.md
# Loop Iteration Counter

This block keeps the iteration count of a hardware loop inside a microcoded sequencer. When a load command arrives with at least one source bit set, it captures a starting value from one of six places: the instruction's immediate field, the ALU result, or one of four working registers. It stores the value either unchanged or multiplied by two. The counter then steps down by two on each decrement event.

The load command also fixes the decrement timing for the loop. In one setting the counter steps on every clock. In the other it steps only on cycles that carry a data-valid strobe. On the decrement that finishes the loop, the block raises a one-cycle last-iteration flag. It also holds a request-next-data level that a pulse can set. If the loop was loaded with the auto-clear option, that level drops at the final iteration of the loop.

The sequencer's decoder drives the load controls directly from its instruction fields. It watches the active flag and the last-iteration flag to decide when to branch back and when to fall through.

Top module: `loop_counter_unit`

## Requirements
- R1: A load (`lc_load` high with at least one `lc_src` bit set) with `lc_exact` = 1 makes `loop_count` equal to the selected source value, zero-extended, on the next cycle.
- R2: A load with `lc_exact` = 0 makes `loop_count` equal to twice the selected source value. The counter is one bit wider than the sources, so doubling the largest source value loses nothing.
- R3: Source bits in `lc_src`: bit 0 immediate, bit 1 ALU result, bit 2 working register 1, bit 3 register 2, bit 4 register 3, bit 5 register 4. When several bits are set, the lowest set bit wins.
- R4: `lc_load` with `lc_src` all zero is ignored: the count and the latched loop settings are unchanged, and decrementing continues as before.
- R5: Each decrement of a count above 2 lowers it by exactly 2.
- R6: The `lc_every_clk` value captured at load selects the decrement event: 1 means every clock, 0 means only cycles with `data_valid` high. Changing the input after the load has no effect on the running loop.
- R7: `loop_last` is high in the cycle where the count is 1 or 2, a decrement event occurs and no load is taken. The count then becomes 0 and stays 0 until the next load, without wrapping. `loop_active` is high exactly when the count is nonzero.
- R8: When a load and a decrement event fall in the same cycle, the load wins and the count takes the new value.
- R9: A `req_set` pulse raises `req_pending` on the next cycle. If the running loop carries the auto-clear option, `req_pending` is low on the cycle after `loop_last`. This clear wins over a `req_set` pulse in the same cycle.
- R10: The auto-clear option is captured from `lc_clr_req` at load time and covers only that loop. A loop loaded without it leaves `req_pending` high through its last iteration.
- R11: While `rst` is high and after its release, before any load, `loop_count` is 0 and `loop_active`, `loop_last` and `req_pending` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lc_load | input | 1 | Load command |
| lc_exact | input | 1 | 1: load value as given, 0: load doubled |
| lc_every_clk | input | 1 | Decrement timing captured at load |
| lc_clr_req | input | 1 | Auto-clear option captured at load |
| lc_src | input | 6 | Load source select bits |
| imm_data | input | DATA_W | Immediate data |
| alu_result | input | DATA_W | ALU output |
| wreg1 | input | DATA_W | Working register 1 |
| wreg2 | input | DATA_W | Working register 2 |
| wreg3 | input | DATA_W | Working register 3 |
| wreg4 | input | DATA_W | Working register 4 |
| data_valid | input | 1 | Data-valid strobe |
| req_set | input | 1 | Sets the request-next-data level |
| loop_count | output | DATA_W+1 | Current count |
| loop_active | output | 1 | Count is nonzero |
| loop_last | output | 1 | Final loop iteration this cycle |
| req_pending | output | 1 | Request-next-data level |

## Verification
The bench targets odd starting counts that finish through 1 rather than 2. A design that tests for exactly 2 would wrap to a huge value or never flag the end. It loads the largest source value doubled; a counter that is too narrow would lose the top bit. It fires a load in the same cycle as a decrement; a design with the priority reversed would show the old count minus two. It sets several source bits at once, where a wrong priority picks the wrong register. It raises a request in the same cycle the loop ends, and runs a second loop without the auto-clear option. A design that does not latch the option per loop would drop the request in that second loop or keep it in the first. It also flips the timing input mid-loop; a design that reads it live would start decrementing without data-valid.

// File: rtl/lcu_pkg.sv
package lcu_pkg;

    localparam int LCU_NSRC   = 6;
    localparam int LCU_SLOTS  = 8;
    localparam int LCU_STEP   = 2;

    typedef enum logic [2:0] {
        SRC_IMM = 3'd0,
        SRC_ALU = 3'd1,
        SRC_WR1 = 3'd2,
        SRC_WR2 = 3'd3,
        SRC_WR3 = 3'd4,
        SRC_WR4 = 3'd5
    } lcu_src_e;

    // settings captured with each load, held for the life of the loop
    typedef struct packed {
        logic every_clk;
        logic clr_req;
    } lcu_mode_t;

    typedef struct packed {
        logic     hit;
        lcu_src_e idx;
    } lcu_pick_t;

    // lowest set select bit wins
    function automatic lcu_pick_t lcu_first(input logic [LCU_NSRC-1:0] sel);
        lcu_pick_t p;
        p.hit = 1'b0;
        p.idx = SRC_IMM;
        for (int i = LCU_NSRC - 1; i >= 0; i--) begin
            if (sel[i]) begin
                p.hit = 1'b1;
                p.idx = lcu_src_e'(i[2:0]);
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/lcu_src_mux.sv
module lcu_src_mux
    import lcu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [LCU_NSRC-1:0] sel,
    input  logic [DATA_W-1:0]   imm,
    input  logic [DATA_W-1:0]   alu,
    input  logic [DATA_W-1:0]   wr1,
    input  logic [DATA_W-1:0]   wr2,
    input  logic [DATA_W-1:0]   wr3,
    input  logic [DATA_W-1:0]   wr4,
    output logic [DATA_W-1:0]   val,
    output logic                hit
);

    logic [DATA_W-1:0] slots [LCU_SLOTS];
    lcu_pick_t         pick;

    assign slots[SRC_IMM] = imm;
    assign slots[SRC_ALU] = alu;
    assign slots[SRC_WR1] = wr1;
    assign slots[SRC_WR2] = wr2;
    assign slots[SRC_WR3] = wr3;
    assign slots[SRC_WR4] = wr4;

    // unused slots of the index space read as zero
    generate
        for (genvar g = LCU_NSRC; g < LCU_SLOTS; g++) begin : g_pad
            assign slots[g] = '0;
        end
    endgenerate

    assign pick = lcu_first(sel);
    assign hit  = pick.hit;
    assign val  = slots[pick.idx];

endmodule

// File: rtl/lcu_count_core.sv
module lcu_count_core
    import lcu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic              exact,
    input  logic [DATA_W-1:0] load_val,
    input  logic              dec_ev,
    output logic [CNT_W-1:0]  count,
    output logic              last
);

    localparam logic [CNT_W-1:0] STEP = CNT_W'(LCU_STEP);

    logic [CNT_W-1:0] wide;
    logic [CNT_W-1:0] loaded;
    logic             near_end;
    logic             active;

    assign wide     = CNT_W'(load_val);
    assign loaded   = exact ? wide : (wide << 1);
    assign near_end = (count <= STEP);
    assign active   = (count != '0);
    assign last     = !load_en && active && dec_ev && near_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load_en) begin
            count <= loaded;
        end else if (active && dec_ev) begin
            count <= near_end ? '0 : (count - STEP);
        end
    end

endmodule

// File: rtl/lcu_req_flag.sv
module lcu_req_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_pulse,
    input  logic clr_hit,
    output logic req
);

    always_ff @(posedge clk) begin
        if (rst) begin
            req <= 1'b0;
        end else if (clr_hit) begin
            req <= 1'b0;
        end else if (set_pulse) begin
            req <= 1'b1;
        end
    end

endmodule

// File: rtl/loop_counter_unit.sv
module loop_counter_unit
    import lcu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                lc_load,
    input  logic                lc_exact,
    input  logic                lc_every_clk,
    input  logic                lc_clr_req,
    input  logic [5:0]          lc_src,
    input  logic [DATA_W-1:0]   imm_data,
    input  logic [DATA_W-1:0]   alu_result,
    input  logic [DATA_W-1:0]   wreg1,
    input  logic [DATA_W-1:0]   wreg2,
    input  logic [DATA_W-1:0]   wreg3,
    input  logic [DATA_W-1:0]   wreg4,
    input  logic                data_valid,
    input  logic                req_set,
    output logic [DATA_W:0]     loop_count,
    output logic                loop_active,
    output logic                loop_last,
    output logic                req_pending
);

    localparam int CNT_W = DATA_W + 1;

    logic [DATA_W-1:0] src_val;
    logic              src_hit;
    logic              load_en;
    logic              dec_ev;
    logic              clr_hit;
    lcu_mode_t         mode_q;

    lcu_src_mux #(.DATA_W(DATA_W)) u_mux (
        .sel (lc_src),
        .imm (imm_data),
        .alu (alu_result),
        .wr1 (wreg1),
        .wr2 (wreg2),
        .wr3 (wreg3),
        .wr4 (wreg4),
        .val (src_val),
        .hit (src_hit)
    );

    assign load_en = lc_load && src_hit;
    assign dec_ev  = mode_q.every_clk || data_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (load_en) begin
            mode_q.every_clk <= lc_every_clk;
            mode_q.clr_req   <= lc_clr_req;
        end else if (loop_last) begin
            mode_q.clr_req <= 1'b0;
        end
    end

    lcu_count_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .load_en  (load_en),
        .exact    (lc_exact),
        .load_val (src_val),
        .dec_ev   (dec_ev),
        .count    (loop_count),
        .last     (loop_last)
    );

    assign clr_hit     = loop_last && mode_q.clr_req;
    assign loop_active = (loop_count != '0);

    lcu_req_flag u_req (
        .clk       (clk),
        .rst       (rst),
        .set_pulse (req_set),
        .clr_hit   (clr_hit),
        .req       (req_pending)
    );

endmodule

// File: rtl/lcu_checker.sv
module lcu_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              lc_load,
    input logic              lc_exact,
    input logic [5:0]        lc_src,
    input logic [DATA_W-1:0] imm_data,
    input logic              data_valid,
    input logic              req_set,
    input logic [DATA_W:0]   loop_count,
    input logic              loop_last,
    input logic              req_pending
);

    localparam int CNT_W = DATA_W + 1;

    logic take_load;
    assign take_load = lc_load && (lc_src != '0);

    a_r1_exact_imm: assert property (@(posedge clk) disable iff (rst)
        (lc_load && lc_src[0] && lc_exact) |=> loop_count == CNT_W'($past(imm_data)));

    a_r2_double_imm: assert property (@(posedge clk) disable iff (rst)
        (lc_load && lc_src[0] && !lc_exact) |=> loop_count == (CNT_W'($past(imm_data)) << 1));

    a_r5_step_two: assert property (@(posedge clk) disable iff (rst)
        (!take_load && data_valid && loop_count > CNT_W'(2)) |=> loop_count == $past(loop_count) - CNT_W'(2));

    a_r7_last_range: assert property (@(posedge clk) disable iff (rst)
        loop_last |-> (loop_count != '0 && loop_count <= CNT_W'(2)));

    a_r7_ends_zero: assert property (@(posedge clk) disable iff (rst)
        loop_last |=> loop_count == '0);

    a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (loop_count == '0 && !take_load) |=> loop_count == '0);

    a_r9_req_set: assert property (@(posedge clk) disable iff (rst)
        (req_set && !loop_last) |=> req_pending);

endmodule

bind loop_counter_unit lcu_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .lc_load     (lc_load),
    .lc_exact    (lc_exact),
    .lc_src      (lc_src),
    .imm_data    (imm_data),
    .data_valid  (data_valid),
    .req_set     (req_set),
    .loop_count  (loop_count),
    .loop_last   (loop_last),
    .req_pending (req_pending)
);

// File: tb/loop_counter_unit_bench.sv
`timescale 1ns/1ps
module loop_counter_unit_bench;

    localparam int DW = 16;
    localparam int CW = DW + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lc_load = 0, lc_exact = 0, lc_every_clk = 0, lc_clr_req = 0;
    logic [5:0]    lc_src = '0;
    logic [DW-1:0] imm_data = '0, alu_result = '0;
    logic [DW-1:0] wreg1 = '0, wreg2 = '0, wreg3 = '0, wreg4 = '0;
    logic          data_valid = 0, req_set = 0;
    logic [CW-1:0] loop_count;
    logic          loop_active, loop_last, req_pending;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    // bench reference state
    logic [CW-1:0] m_cnt = '0;
    bit m_every = 0, m_clr = 0, m_req = 0;

    always #2 clk = ~clk;

    loop_counter_unit #(.DATA_W(DW)) u_loop_counter_unit (
        .clk(clk), .rst(rst), .lc_load(lc_load), .lc_exact(lc_exact),
        .lc_every_clk(lc_every_clk), .lc_clr_req(lc_clr_req), .lc_src(lc_src),
        .imm_data(imm_data), .alu_result(alu_result), .wreg1(wreg1),
        .wreg2(wreg2), .wreg3(wreg3), .wreg4(wreg4), .data_valid(data_valid),
        .req_set(req_set), .loop_count(loop_count), .loop_active(loop_active),
        .loop_last(loop_last), .req_pending(req_pending)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pick_src(input logic [5:0] s);
        if (s[0]) return imm_data;
        if (s[1]) return alu_result;
        if (s[2]) return wreg1;
        if (s[3]) return wreg2;
        if (s[4]) return wreg3;
        return wreg4;
    endfunction

    // one cycle: inputs already set at the falling edge
    task automatic cyc(input string tag);
        bit ld, dec, lst;
        logic [CW-1:0] nv;
        #0.5;
        ld  = lc_load && (lc_src != 0);
        dec = m_every || data_valid;
        lst = !ld && (m_cnt != 0) && dec && (m_cnt <= 2);
        check(loop_last == lst, tag, "loop_last", int'(loop_last), int'(lst));
        if (lst && m_clr) m_req = 0;
        else if (req_set) m_req = 1;
        if (ld) begin
            nv = CW'(pick_src(lc_src));
            m_cnt = lc_exact ? nv : (nv << 1);
            m_every = lc_every_clk;
            m_clr = lc_clr_req;
        end else begin
            if (m_cnt != 0 && dec) m_cnt = (m_cnt <= 2) ? '0 : m_cnt - 2;
            if (lst) m_clr = 0;
        end
        @(posedge clk);
        #0.5;
        check(loop_count == m_cnt, tag, "loop_count", int'(loop_count), int'(m_cnt));
        check(loop_active == (m_cnt != 0), tag, "loop_active", int'(loop_active), int'(m_cnt != 0));
        check(req_pending == m_req, tag, "req_pending", int'(req_pending), int'(m_req));
        @(negedge clk);
    endtask

    task automatic drive(input bit ld, input bit ex, input bit ev, input bit cr,
                         input logic [5:0] s, input logic [DW-1:0] imm,
                         input bit dv, input bit rs);
        lc_load = ld; lc_exact = ex; lc_every_clk = ev; lc_clr_req = cr;
        lc_src = s; imm_data = imm; data_valid = dv; req_set = rs;
    endtask

    task automatic idle(input int n, input bit dv, input string tag);
        for (int i = 0; i < n; i++) begin
            drive(0, 0, 0, 0, 6'd0, 16'h0, dv, 0);
            cyc(tag);
        end
    endtask

    initial begin
        #400000;
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        bit ld, ex, ev, cr, dv, rs;
        logic [5:0] s;
        logic [DW-1:0] v;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R11: reset state, with reset still high
        check(loop_count == 0 && !loop_active && !loop_last && !req_pending,
              "R11", "reset outputs", int'(loop_count), 0);
        rst = 1'b0;
        idle(2, 1, "R11");

        // R1 exact load, every clock, odd count 7 -> 5 3 1 0
        drive(1, 1, 1, 0, 6'b000001, 16'd7, 0, 0); cyc("R1");
        check(loop_count == 7, "R1", "exact immediate", int'(loop_count), 7);
        idle(2, 0, "R5");
        idle(3, 0, "R7");
        check(loop_count == 0 && !loop_active, "R7", "settled zero", int'(loop_count), 0);

        // R2 doubled load, data-valid timing
        drive(1, 0, 0, 0, 6'b000001, 16'd3, 1, 0); cyc("R2");
        check(loop_count == 6, "R2", "doubled immediate", int'(loop_count), 6);
        // R6: timing input flipped after load must not matter
        lc_every_clk = 1;
        for (int i = 0; i < 3; i++) begin
            drive(0, 0, 1, 0, 6'd0, 16'h0, 0, 0); cyc("R6");
        end
        check(loop_count == 6, "R6", "hold without data_valid", int'(loop_count), 6);
        idle(4, 1, "R6");

        // R2 widest value doubled
        drive(1, 0, 1, 0, 6'b000001, 16'hFFFF, 0, 0); cyc("R2");
        check(loop_count == 17'h1FFFE, "R2", "max doubled", int'(loop_count), 32'h1FFFE);

        // R3 priority
        alu_result = 16'd100; wreg1 = 16'd200; wreg2 = 16'd300; wreg3 = 16'd400; wreg4 = 16'd500;
        drive(1, 1, 0, 0, 6'b111110, 16'd9, 0, 0); cyc("R3");
        check(loop_count == 100, "R3", "ALU over registers", int'(loop_count), 100);
        drive(1, 1, 0, 0, 6'b110000, 16'd9, 0, 0); cyc("R3");
        check(loop_count == 400, "R3", "WR3 over WR4", int'(loop_count), 400);
        drive(1, 1, 0, 0, 6'b100000, 16'd9, 0, 0); cyc("R3");
        check(loop_count == 500, "R3", "WR4 alone", int'(loop_count), 500);
        drive(1, 1, 0, 0, 6'b001100, 16'd9, 0, 0); cyc("R3");
        check(loop_count == 200, "R3", "WR1 over WR2", int'(loop_count), 200);

        // R4 load with no source: ignored, decrement continues
        drive(1, 1, 1, 1, 6'b000000, 16'd50, 1, 0); cyc("R4");
        check(loop_count == 198, "R4", "no-source load", int'(loop_count), 198);

        // R8 load wins over decrement
        drive(1, 1, 1, 0, 6'b000001, 16'd11, 0, 0); cyc("R8");
        drive(1, 1, 1, 0, 6'b000001, 16'd20, 1, 0); cyc("R8");
        check(loop_count == 20, "R8", "load over decrement", int'(loop_count), 20);

        // R9 auto-clear at end of loop
        drive(1, 1, 1, 1, 6'b000001, 16'd5, 0, 1); cyc("R9");
        idle(3, 0, "R9");
        check(!req_pending, "R9", "cleared at last", int'(req_pending), 0);
        // R10 next loop without option keeps the request
        drive(1, 1, 1, 0, 6'b000001, 16'd4, 0, 1); cyc("R10");
        idle(3, 0, "R10");
        check(req_pending, "R10", "kept without option", int'(req_pending), 1);
        // R9 collision: set in the clearing cycle, clear wins
        drive(1, 1, 1, 1, 6'b000001, 16'd2, 0, 0); cyc("R9");
        drive(0, 0, 0, 0, 6'd0, 16'h0, 0, 1); cyc("R9");
        check(!req_pending, "R9", "clear beats set", int'(req_pending), 0);
        drive(0, 0, 0, 0, 6'd0, 16'h0, 0, 1); cyc("R9");
        check(req_pending, "R9", "set after loop", int'(req_pending), 1);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            ld = ($urandom % 16) == 0;
            ex = $urandom % 2; ev = $urandom % 2; cr = $urandom % 2;
            s  = ($urandom % 4 == 0) ? 6'd0 : 6'($urandom);
            v  = ($urandom % 10 == 0) ? 16'($urandom) : 16'($urandom % 24);
            dv = $urandom % 2; rs = ($urandom % 8) == 0;
            if ($urandom % 4 == 0) begin
                alu_result = 16'($urandom % 30); wreg1 = 16'($urandom % 30);
                wreg2 = 16'($urandom % 30); wreg3 = 16'($urandom % 30);
                wreg4 = 16'($urandom % 30);
            end
            drive(ld, ex, ev, cr, s, v, dv, rs);
            cyc("R5");
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule